// File: doc/BRIEF.md
# Successive Approximation Fractional Divider

This block computes the unsigned fraction N/D as a 16-bit membership value. The scale puts 0 at 0000h and full membership at FFFFh. It is meant to sit behind the slope comparators of a trapezoidal membership evaluator, where the numerator is a distance into the slope and the divisor is the full width of the slope. Because the numerator is smaller than the divisor there, the quotient is always a pure fraction.

A rising edge on the start input captures both operands. The block then works through a fixed number of iterations. In each one it builds the seven nonzero multiples of the divisor by shift-and-add, compares eight times the running remainder against them, and takes the index of the enclosing region as the next three quotient bits. The lower bound of that region is removed, and what is left becomes the new remainder. After the last iteration the block publishes the truncated result together with a one-cycle valid strobe. The result then stays on the output until the next division completes.

Top module: `sa_frac_div`

## Requirements
- R1: While reset is high and on the cycle after it, `quo` is 0000h and `valid` is 0.
- R2: For 0 < D and N < D, the published `quo` equals floor(N·65536/D). This is the upper 16 of 18 quotient bits, resolved three at a time from the most significant end.
- R3: `valid` rises on the 7th rising clock edge after the edge that samples a start rise. That is one edge per iteration for six iterations plus one publishing edge.
- R4: `valid` is high for exactly one clock cycle per accepted division.
- R5: `quo` changes only on the edge that raises `valid`, and holds its value between strobes.
- R6: A start rise is ignored when it is sampled on any edge from the accepting edge through the edge that raises `valid`. The division already running completes with its own operands.
- R7: Only a low-to-high transition of `start` launches a division; holding `start` high launches exactly one.
- R8: With D = 0 the result is 0000h, delivered with the normal latency and strobe.
- R9: With D ≠ 0 and N ≥ D the result saturates to FFFFh, delivered with the normal latency and strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch request; its rising edge captures the operands |
| num | input | 16 | Numerator N, unsigned |
| den | input | 16 | Divisor D, unsigned |
| quo | output | 16 | Fractional quotient, registered |
| valid | output | 1 | One-cycle strobe marking a fresh quotient |

## Verification
A corrupted remainder or a wrong region pick shows up only at the next strobe. There it appears as a wrong `quo`, and an error in an early iteration moves the high bits by large amounts. A miscounted iteration counter moves the `valid` strobe off its seventh edge, so a per-cycle comparison against the reference flags it within the same division. A broken edge detector or busy guard shows up as an extra or missing strobe, or as a result from the wrong operand pair. These faults become visible at most eight cycles after the offending start.

// File: rtl/sa_div_pkg.sv
package sa_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } sa_state_t;
endpackage

// File: rtl/sa_multiples.sv
// Builds k*den for every region index k by shift-and-add.
module sa_multiples #(
  parameter int W  = 16,
  parameter int RB = 3
) (
  input  logic [W-1:0]                     den,
  output logic [(1<<RB)-1:0][W+RB-1:0]     mult
);
  localparam int NR = 1 << RB;
  localparam int MW = W + RB;

  logic [MW-1:0] den_ext;
  assign den_ext = {{RB{1'b0}}, den};

  for (genvar k = 0; k < NR; k++) begin : g_mult
    always_comb begin
      mult[k] = '0;
      for (int b = 0; b < RB; b++) begin
        if (((k >> b) & 1) == 1)
          mult[k] = mult[k] + (den_ext << b);
      end
    end
  end
endmodule

// File: rtl/sa_digit_sel.sv
// Picks the region that holds the scaled remainder and strips its lower bound.
module sa_digit_sel #(
  parameter int W  = 16,
  parameter int RB = 3
) (
  input  logic [W-1:0]                 rem,
  input  logic [(1<<RB)-1:0][W+RB-1:0] mult,
  output logic [RB-1:0]                digit,
  output logic [W-1:0]                 rem_next
);
  localparam int NR = 1 << RB;
  localparam int MW = W + RB;

  logic [MW-1:0] scaled;
  logic [NR-1:0] at_or_above;
  logic [MW-1:0] diff;

  assign scaled = {rem, {RB{1'b0}}};

  for (genvar k = 0; k < NR; k++) begin : g_cmp
    assign at_or_above[k] = (scaled >= mult[k]);
  end

  always_comb begin
    digit = '0;
    for (int k = 1; k < NR; k++) begin
      if (at_or_above[k]) digit = RB'(k);
    end
  end

  assign diff     = scaled - mult[digit];
  assign rem_next = W'(diff);
endmodule

// File: rtl/sa_iter_ctrl.sv
// Start edge detection, busy guard and iteration counting.
module sa_iter_ctrl
  import sa_div_pkg::*;
#(
  parameter int ITERS = 6
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  output sa_state_t state,
  output logic      load,
  output logic      step,
  output logic      fin
);
  localparam int CW = $clog2(ITERS + 1);

  logic          start_q;
  logic [CW-1:0] cnt;
  logic          rise;

  assign rise = start & ~start_q;
  assign load = (state == ST_IDLE) && rise;
  assign step = (state == ST_RUN);
  assign fin  = (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      state   <= ST_IDLE;
      cnt     <= '0;
    end else begin
      start_q <= start;
      unique case (state)
        ST_IDLE: if (rise) begin
          state <= ST_RUN;
          cnt   <= '0;
        end
        ST_RUN: begin
          if (cnt == CW'(ITERS - 1)) state <= ST_FIN;
          else cnt <= cnt + 1'b1;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (cnt < CW'(ITERS))); // R3
  AST_FIN_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIN) |-> ($past(state) == ST_RUN && $past(cnt) == CW'(ITERS - 1))); // R3
  AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && cnt == '0) |-> ($past(state) == ST_IDLE)); // R6
endmodule

// File: rtl/sa_frac_div.sv
module sa_frac_div
  import sa_div_pkg::*;
#(
  parameter int W     = 16,
  parameter int OUT_W = 16,
  parameter int RB    = 3,
  parameter int ITERS = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [W-1:0]     num,
  input  logic [W-1:0]     den,
  output logic [OUT_W-1:0] quo,
  output logic             valid
);
  localparam int NR = 1 << RB;
  localparam int MW = W + RB;
  localparam int QW = ITERS * RB;

  sa_state_t         state;
  logic              load, step, fin;
  logic [W-1:0]      rem, dsr, rem_next;
  logic [QW-1:0]     qacc;
  logic [RB-1:0]     digit;
  logic              zflag, sflag;
  logic [NR-1:0][MW-1:0] mult;

  sa_iter_ctrl #(.ITERS(ITERS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .state(state), .load(load), .step(step), .fin(fin)
  );

  sa_multiples #(.W(W), .RB(RB)) u_mult (
    .den(dsr), .mult(mult)
  );

  sa_digit_sel #(.W(W), .RB(RB)) u_sel (
    .rem(rem), .mult(mult), .digit(digit), .rem_next(rem_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      dsr   <= '0;
      qacc  <= '0;
      zflag <= 1'b0;
      sflag <= 1'b0;
      quo   <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (load) begin
        zflag <= (den == '0);
        sflag <= (den != '0) && (num >= den);
        rem   <= ((den == '0) || (num >= den)) ? '0 : num;
        dsr   <= den;
        qacc  <= '0;
      end else if (step) begin
        qacc <= {qacc[QW-RB-1:0], digit};
        rem  <= rem_next;
      end else if (fin) begin
        valid <= 1'b1;
        if (zflag)      quo <= '0;
        else if (sflag) quo <= '1;
        else            quo <= qacc[QW-1 -: OUT_W];
      end
    end
  end

  AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !zflag && !sflag) |-> (rem < dsr)); // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R4
  AST_QUO_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(quo) |-> valid); // R5
  AST_ZERO_DEN: assert property (@(posedge clk) disable iff (rst)
    (fin && zflag) |=> (valid && quo == '0)); // R8
  AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (fin && sflag) |=> (valid && quo == '1)); // R9
endmodule

// File: tb/tb_sa_frac_div.sv
`timescale 1ns/1ps
module tb_sa_frac_div;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] num = '0, den = '0;
  logic [15:0] quo;
  logic        valid;

  int    checks = 0;
  int    failures = 0;
  string cur_tag = "R1";
  bit    finished = 0;

  always #5 clk = ~clk;

  sa_frac_div dut (
    .clk(clk), .rst(rst), .start(start), .num(num), .den(den),
    .quo(quo), .valid(valid)
  );

  function automatic logic [15:0] expect_q(input logic [15:0] n, input logic [15:0] d);
    longint r;
    if (d == 0) return 16'h0000;
    if (n >= d) return 16'hFFFF;
    r = (longint'(n) * 65536) / longint'(d);
    return 16'(r);
  endfunction

  // Behavioural reference: countdown after an accepted start rise.
  int          m_left = 0;
  logic        m_sq = 0;
  logic        m_valid = 0;
  logic [15:0] m_quo = 0, m_res = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_left = 0; m_sq = 0; m_valid = 0; m_quo = 0;
    end else begin
      m_valid = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin
          m_valid = 1;
          m_quo = m_res;
        end
      end else if (start && !m_sq) begin
        m_left = 7;
        m_res = expect_q(num, den);
      end
      m_sq = start;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (quo !== m_quo || valid !== m_valid) begin
        failures++;
        $display("FAIL %s per-cycle: quo=%h valid=%b expected quo=%h valid=%b",
                 cur_tag, quo, valid, m_quo, m_valid);
      end
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic do_div(input logic [15:0] n, input logic [15:0] d, input string tag);
    int cyc;
    cur_tag = tag;
    @(negedge clk); start = 1; num = n; den = d;
    @(negedge clk); start = 0;
    cyc = 1;
    while (!valid && cyc < 20) begin
      @(negedge clk); cyc++;
    end
    check({tag, " R3 latency"}, cyc, 8);
    check({tag, " result"}, quo, expect_q(n, d));
    @(negedge clk);
    check({tag, " R4 pulse"}, valid, 0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] lcg;
    logic [15:0] hold_q, expa;
    int vcount;
    repeat (3) @(negedge clk);
    check("R1 quo in reset", quo, 0);
    check("R1 valid in reset", valid, 0);
    rst = 0;
    @(negedge clk);
    check("R1 quo after reset", quo, 0);

    do_div(16'd1, 16'd3, "R2");
    do_div(16'd0, 16'd77, "R2");
    do_div(16'hFFFE, 16'hFFFF, "R2");
    do_div(16'd1, 16'hFFFF, "R2");
    do_div(16'h7FFF, 16'h8000, "R2");
    do_div(16'd6, 16'd7, "R2");
    lcg = 32'h1234_5678;
    for (int i = 0; i < 40; i++) begin
      logic [15:0] d, n;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      d = lcg[31:16] | 16'd1;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      n = 16'(lcg[31:16] % d);
      do_div(n, d, "R2");
    end

    // R5: output holds with no activity
    cur_tag = "R5";
    hold_q = quo;
    repeat (20) @(negedge clk);
    check("R5 hold", quo, hold_q);

    // R8 / R9
    do_div(16'd1234, 16'd0, "R8");
    do_div(16'd5, 16'd5, "R9");
    do_div(16'hFFFF, 16'd1, "R9");

    // R6: new rise during busy is ignored
    cur_tag = "R6";
    expa = expect_q(16'd100, 16'd300);
    @(negedge clk); start = 1; num = 16'd100; den = 16'd300;
    @(negedge clk); start = 0;
    @(negedge clk); @(negedge clk);
    start = 1; num = 16'd299; den = 16'd300;
    @(negedge clk); start = 0;
    vcount = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (valid) vcount++;
    end
    check("R6 one strobe", vcount, 1);
    check("R6 first operands", quo, expa);

    // R7: start held high launches once
    cur_tag = "R7";
    @(negedge clk); start = 1; num = 16'd9; den = 16'd10;
    vcount = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (valid) vcount++;
    end
    start = 0;
    check("R7 one strobe", vcount, 1);
    check("R7 result", quo, expect_q(16'd9, 16'd10));
    repeat (3) @(negedge clk);
    summary();
  end
endmodule